// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter

This block is the arbitration slice that each processor on a shared external bus carries. Up to `NPROC` processors and one host are connected to the same bus. Every processor drives one request line, and every node sees the full request vector. The shared lock line and the host request are also visible to all nodes. Because every node runs the same registered decision on the same inputs, all nodes name the same bus master in the same cycle. No central arbiter is needed.

Processors are ranked in one of two ways. In fixed order, the lowest index wins. In rotating order, the search begins just after the processor that last gave up the bus. A master that is not locked gives up the bus as soon as the host asks or a processor ranked above it asks. A master that holds the shared lock line keeps the bus whatever else is pending, so a read-modify-write stays indivisible. When the bus is free, the host outranks all processors.

Every change of master passes through exactly one cycle in which nobody owns the bus.

Top module: `mparb_node`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `master_vld`, `host_grant` and `own_grant` are 0. The rotation pointer resets to index `NPROC-1`, so the first rotating search starts at index 0.
- R2: When the bus is free and `host_req` is 0, a set request bit seen at a rising edge makes `master_vld` 1 right after that edge. With `prio_rotate`=0 the lowest set index of `bus_req` (bit i belongs to processor i) appears on `master_id`.
- R3: With `prio_rotate`=1 the winner is the first set request found by searching upward, with wrap, from the index after the last processor that released the bus.
- R4: Between two different masters (processor or host) there is exactly one cycle with both `master_vld` and `host_grant` at 0.
- R5: An unlocked processor master keeps the bus while it is still the winner of the current ranking. It releases the bus when its own request drops, when a processor ranked above it requests, or when `host_req` is 1.
- R6: While `bus_lock` is 1 and a processor owns the bus, that processor stays master. This holds even with its own request low, with higher-ranked requests pending, and with `host_req` at 1.
- R7: On a free bus `host_req`=1 grants the host ahead of any processor. `host_grant` then stays 1 until `host_req` falls, and `host_grant` and `master_vld` are never 1 together.
- R8: `own_grant` is 1 exactly when `master_vld` is 1 and `master_id` equals `node_id`. Two nodes fed the same bus signals report the same `master_vld` and `master_id` every cycle.
- R9: `bus_lock` has no effect while the bus is free or owned by the host.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock shared by all nodes |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | $clog2(NPROC) | Index of this node, strapped per processor |
| prio_rotate | input | 1 | 0 = fixed ranking, 1 = rotating ranking |
| bus_req | input | NPROC | Request lines of all processors, bit i = processor i |
| bus_lock | input | 1 | Shared lock line driven by the current master |
| host_req | input | 1 | Host bus request |
| host_grant | output | 1 | Host owns the bus |
| master_vld | output | 1 | A processor owns the bus |
| master_id | output | $clog2(NPROC) | Index of the owning processor |
| own_grant | output | 1 | This node owns the bus |

## Verification
The bench builds two nodes with the default `NPROC`=6 and `ROTATE_EN`=1, strapped to indices 1 and 4. Both are fed identical bus signals, so agreement between nodes and each node's own grant can be observed together. Six processors make a full wrap of the rotating search reachable. They also allow preemption from both ends of the ranking and a locked master with five competitors pending. A behavioural model follows every cycle of directed sequences and a long random stretch in both ranking modes.

// File: rtl/mparb_pkg.sv
package mparb_pkg;

   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_PROC = 2'd1,
      OWN_HOST = 2'd2
   } own_kind_e;

endpackage

// File: rtl/mparb_pick.sv
module mparb_pick #(
   parameter int NPROC     = 6,
   parameter bit ROTATE_EN = 1'b1,
   localparam int IDW      = (NPROC > 1) ? $clog2(NPROC) : 1
) (
   input  logic [NPROC-1:0] req,
   input  logic             rotate,
   input  logic [IDW-1:0]   last_id,
   output logic             win_any,
   output logic [IDW-1:0]   win_id
);

   logic           fx_found;
   logic [IDW-1:0] fx_id;

   always_comb begin
      fx_found = 1'b0;
      fx_id    = '0;
      for (int i = 0; i < NPROC; i++) begin
         if (req[i] && !fx_found) begin
            fx_found = 1'b1;
            fx_id    = IDW'(i);
         end
      end
   end

   assign win_any = |req;

   generate
      if (ROTATE_EN) begin : g_rot
         logic           rt_found;
         logic [IDW-1:0] rt_id;

         always_comb begin
            rt_found = 1'b0;
            rt_id    = '0;
            for (int off = 1; off <= NPROC; off++) begin
               int idx;
               idx = (int'(last_id) + off) % NPROC;
               if (req[idx] && !rt_found) begin
                  rt_found = 1'b1;
                  rt_id    = IDW'(idx);
               end
            end
         end

         assign win_id = rotate ? rt_id : fx_id;
      end else begin : g_fixed
         assign win_id = fx_id;
      end
   endgenerate

endmodule

// File: rtl/mparb_state.sv
module mparb_state
   import mparb_pkg::*;
#(
   parameter int NPROC = 6,
   localparam int IDW  = (NPROC > 1) ? $clog2(NPROC) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           host_req,
   input  logic           bus_lock,
   input  logic           win_any,
   input  logic [IDW-1:0] win_id,
   output own_kind_e      kind,
   output logic [IDW-1:0] owner_id,
   output logic [IDW-1:0] last_id
);

   localparam logic [IDW-1:0] LAST_RST = IDW'(NPROC - 1);

   own_kind_e      kind_n;
   logic [IDW-1:0] owner_n;
   logic [IDW-1:0] last_n;

   always_comb begin
      kind_n  = kind;
      owner_n = owner_id;
      last_n  = last_id;
      unique case (kind)
         OWN_NONE: begin
            if (host_req) begin
               kind_n = OWN_HOST;
            end else if (win_any) begin
               kind_n  = OWN_PROC;
               owner_n = win_id;
            end
         end
         OWN_PROC: begin
            if (!bus_lock) begin
               if (host_req || !win_any || (win_id != owner_id)) begin
                  kind_n = OWN_NONE;
                  last_n = owner_id;
               end
            end
         end
         OWN_HOST: begin
            if (!host_req) begin
               kind_n = OWN_NONE;
            end
         end
         default: kind_n = OWN_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind     <= OWN_NONE;
         owner_id <= '0;
         last_id  <= LAST_RST;
      end else begin
         kind     <= kind_n;
         owner_id <= owner_n;
         last_id  <= last_n;
      end
   end

endmodule

// File: rtl/mparb_node.sv
module mparb_node
   import mparb_pkg::*;
#(
   parameter int NPROC     = 6,
   parameter bit ROTATE_EN = 1'b1,
   localparam int IDW      = (NPROC > 1) ? $clog2(NPROC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDW-1:0]   node_id,
   input  logic             prio_rotate,
   input  logic [NPROC-1:0] bus_req,
   input  logic             bus_lock,
   input  logic             host_req,
   output logic             host_grant,
   output logic             master_vld,
   output logic [IDW-1:0]   master_id,
   output logic             own_grant
);

   generate
      if (NPROC < 2 || NPROC > 16) begin : g_bad_nproc
         $error("mparb_node: NPROC must lie in 2..16");
      end
   endgenerate

   own_kind_e      kind;
   logic [IDW-1:0] owner_id;
   logic [IDW-1:0] last_id;
   logic           win_any;
   logic [IDW-1:0] win_id;

   mparb_pick #(
      .NPROC     (NPROC),
      .ROTATE_EN (ROTATE_EN)
   ) u_pick (
      .req     (bus_req),
      .rotate  (prio_rotate),
      .last_id (last_id),
      .win_any (win_any),
      .win_id  (win_id)
   );

   mparb_state #(
      .NPROC (NPROC)
   ) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_req (host_req),
      .bus_lock (bus_lock),
      .win_any  (win_any),
      .win_id   (win_id),
      .kind     (kind),
      .owner_id (owner_id),
      .last_id  (last_id)
   );

   assign master_vld = (kind == OWN_PROC);
   assign host_grant = (kind == OWN_HOST);
   assign master_id  = owner_id;
   assign own_grant  = master_vld && (owner_id == node_id);

endmodule

// File: rtl/mparb_node_chk.sv
module mparb_node_chk #(
   parameter int NPROC = 6,
   localparam int IDW  = (NPROC > 1) ? $clog2(NPROC) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPROC-1:0] bus_req,
   input logic             bus_lock,
   input logic             host_req,
   input logic             host_grant,
   input logic             master_vld,
   input logic [IDW-1:0]   master_id
);

   // R7: host and processor ownership are exclusive
   a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_grant && master_vld));

   // R7: host only enters after asking
   a_r7_host_asked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_grant) |-> $past(host_req));

   // R6: locked master stays in place
   a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (master_vld && bus_lock) |=> (master_vld && $stable(master_id)));

   // R4: no direct processor-to-processor switch
   a_r4_no_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (master_vld && $past(master_vld)) |-> (master_id == $past(master_id)));

   // R4: no direct host-to-processor or processor-to-host switch
   a_r4_host_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(host_grant) |-> !master_vld) and ($past(master_vld) |-> !host_grant));

   // R2: a new master was requesting
   a_r2_req_seen: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(master_vld) |-> (($past(bus_req) >> master_id) & NPROC'(1)) != '0);

   // R2: master index within range
   a_r2_id_range: assert property (@(posedge clk) disable iff (!rst_n)
      master_vld |-> (int'(master_id) < NPROC));

endmodule

bind mparb_node mparb_node_chk #(.NPROC(NPROC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_lock   (bus_lock),
   .host_req   (host_req),
   .host_grant (host_grant),
   .master_vld (master_vld),
   .master_id  (master_id)
);

// File: tb/mparb_node_tb_top.sv
module mparb_node_tb_top;

   localparam int CLK_P = 10;
   localparam int N     = 6;
   localparam int IDW   = $clog2(N);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           prio_rotate = 1'b0;
   logic [N-1:0]   bus_req = '0;
   logic           bus_lock = 1'b0;
   logic           host_req = 1'b0;
   logic           host_grant, master_vld, own_grant;
   logic [IDW-1:0] master_id;
   logic           p_host_grant, p_master_vld, p_own_grant;
   logic [IDW-1:0] p_master_id;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   string cur_req = "R1";

   // model state: 0 free, 1 processor, 2 host
   int m_kind = 0;
   int m_id   = 0;
   int m_last = N - 1;

   always #(CLK_P / 2) clk = ~clk;

   mparb_node #(.NPROC(N)) dut_i (
      .clk (clk), .rst_n (rst_n), .node_id (IDW'(1)), .prio_rotate (prio_rotate),
      .bus_req (bus_req), .bus_lock (bus_lock), .host_req (host_req),
      .host_grant (host_grant), .master_vld (master_vld),
      .master_id (master_id), .own_grant (own_grant)
   );

   mparb_node #(.NPROC(N)) peer_i (
      .clk (clk), .rst_n (rst_n), .node_id (IDW'(4)), .prio_rotate (prio_rotate),
      .bus_req (bus_req), .bus_lock (bus_lock), .host_req (host_req),
      .host_grant (p_host_grant), .master_vld (p_master_vld),
      .master_id (p_master_id), .own_grant (p_own_grant)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   function automatic int pick_winner(input logic [N-1:0] r, input bit rot, input int last);
      if (rot) begin
         for (int off = 1; off <= N; off++)
            if (r[(last + off) % N]) return (last + off) % N;
      end else begin
         for (int i = 0; i < N; i++)
            if (r[i]) return i;
      end
      return -1;
   endfunction

   task automatic model_step();
      int w;
      w = pick_winner(bus_req, prio_rotate, m_last);
      if (m_kind == 0) begin
         if (host_req) m_kind = 2;
         else if (w >= 0) begin m_kind = 1; m_id = w; end
      end else if (m_kind == 1) begin
         if (!bus_lock && (host_req || w != m_id)) begin
            m_last = m_id;
            m_kind = 0;
         end
      end else if (!host_req) begin
         m_kind = 0;
      end
   endtask

   task automatic compare_all();
      bit ev;
      ev = (m_kind == 1);
      chk(master_vld == ev, cur_req, int'(master_vld), int'(ev));
      chk(host_grant == (m_kind == 2), cur_req, int'(host_grant), int'(m_kind == 2));
      if (ev) chk(int'(master_id) == m_id, cur_req, int'(master_id), m_id);
      chk(own_grant == (ev && m_id == 1), "R8 own", int'(own_grant), int'(ev && m_id == 1));
      chk(p_own_grant == (ev && m_id == 4), "R8 peer own", int'(p_own_grant), int'(ev && m_id == 4));
      chk(p_master_vld == master_vld && p_host_grant == host_grant &&
          (!master_vld || p_master_id == master_id), "R8 agree",
          int'(p_master_id), int'(master_id));
   endtask

   task automatic cyc(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         if (rst_n) model_step();
         @(negedge clk);
         compare_all();
      end
   endtask

   task automatic drive(input logic [N-1:0] r, input bit lk, input bit h);
      bus_req  = r;
      bus_lock = lk;
      host_req = h;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state, with requests present during reset
      drive(6'b111111, 1'b1, 1'b1);
      repeat (3) begin
         @(negedge clk);
         chk(!master_vld && !host_grant && !own_grant, "R1 reset", int'(master_vld), 0);
      end
      drive('0, 1'b0, 1'b0);
      rst_n = 1'b1;
      cyc(1);
      chk(!master_vld && !host_grant, "R1 after reset", int'(master_vld), 0);

      // R2: fixed ranking, lowest index wins, one cycle latency
      cur_req = "R2";
      prio_rotate = 1'b0;
      drive(6'b101100, 1'b0, 1'b0);
      cyc(1);
      chk(master_vld && master_id == 2, "R2 fixed winner", int'(master_id), 2);

      // R5 / R4: higher-ranked request preempts, one free cycle
      cur_req = "R5";
      drive(6'b101110, 1'b0, 1'b0);
      cyc(1);
      chk(!master_vld && !host_grant, "R4 gap", int'(master_vld), 0);
      cyc(1);
      chk(master_vld && master_id == 1, "R5 preempt", int'(master_id), 1);
      chk(own_grant, "R8 own grant", int'(own_grant), 1);

      // R6: lock holds against everything, own request dropped
      cur_req = "R6";
      drive(6'b111101, 1'b1, 1'b1);
      cyc(4);
      chk(master_vld && master_id == 1 && !host_grant, "R6 locked", int'(master_id), 1);

      // R7: lock released, host takes after one free cycle
      cur_req = "R7";
      drive(6'b111101, 1'b0, 1'b1);
      cyc(1);
      chk(!master_vld && !host_grant, "R4 gap to host", int'(host_grant), 0);
      cyc(1);
      chk(host_grant && !master_vld, "R7 host wins", int'(host_grant), 1);

      // R9: lock during host ownership has no effect
      cur_req = "R9";
      drive(6'b111101, 1'b1, 1'b1);
      cyc(3);
      drive(6'b111101, 1'b1, 1'b0);
      cyc(1);
      chk(!host_grant && !master_vld, "R9 host leaves", int'(host_grant), 0);
      drive('0, 1'b1, 1'b0);
      cyc(3);
      chk(!master_vld && !host_grant, "R9 idle lock", int'(master_vld), 0);

      // R3: rotating ranking (pointer is 1 after the earlier owner)
      cur_req = "R3";
      prio_rotate = 1'b1;
      drive(6'b111111, 1'b0, 1'b0);
      cyc(1);
      chk(master_vld && master_id == 2, "R3 rotate start", int'(master_id), 2);
      cyc(3);
      chk(master_vld && master_id == 2, "R3 holder keeps", int'(master_id), 2);
      drive(6'b111011, 1'b0, 1'b0);
      cyc(2);
      chk(master_vld && master_id == 3, "R3 next in turn", int'(master_id), 3);
      drive(6'b110111, 1'b0, 1'b0);
      cyc(2);
      drive(6'b000011, 1'b0, 1'b0);
      cyc(2);
      chk(master_vld && master_id == 0, "R3 wrap", int'(master_id), 0);

      // random stretch in both modes
      cur_req = "R5";
      drive('0, 1'b0, 1'b0);
      cyc(2);
      for (int t = 0; t < 3000; t++) begin
         if (t % 500 == 0) prio_rotate = ~prio_rotate;
         drive(N'($urandom), ($urandom % 8) == 0, ($urandom % 6) == 0);
         cyc(1);
      end
      drive('0, 1'b0, 1'b0);
      cyc(3);
      finish_run();
   end

endmodule